// File: doc/BRIEF.md
# Modular Inverse Exponentiation Sequencer

This block computes the multiplicative inverse of a field element modulo the prime 2^255 − 19 by raising it to the power p − 2. It does no arithmetic of its own. It drives an external modular multiplier through a fixed schedule of squarings and general products. Each product is an acknowledged request: the operands are held on the request port until the multiplier returns the reduced result.

The schedule builds intermediate powers whose exponents have the form 2^k − 1 and keeps a small slot file of them for reuse. The slot file has four slots plus a running accumulator. A start pulse loads the operand. The block then issues 265 products in a fixed order and pulses done with the inverse on its result port. A zero operand gets no special handling and comes out as zero.

Top module: `inv_chain_seq`

## Requirements
- R1: For a nonzero operand a below p = 2^255 − 19, the result inv satisfies inv = a^(p−2) mod p, so a·inv mod p equals 1.
- R2: One inversion issues exactly 265 multiplier requests, each counted at its acknowledgement.
- R3: Exactly 254 of those requests are squarings, marked by mul_sq_o high. The other 11 are general products with mul_sq_o low.
- R4: Once mul_req_o is high, it stays high and both operands stay unchanged until the cycle in which mul_ack_i is sampled high.
- R5: done_o is high for exactly one cycle. That cycle follows the acknowledgement of the 265th request, and inv_o holds that acknowledgement's result from then until the next accepted start.
- R6: An operand of zero yields a result of zero.
- R7: A start_i pulse while busy_o is high is ignored. The running inversion finishes with the result of its original operand.
- R8: After reset, busy_o, done_o and mul_req_o are low and inv_o is zero.
- R9: During a squaring request (mul_sq_o high), mul_a_o equals mul_b_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts an inversion when the block is idle |
| a_i | input | 255 | Operand, sampled with start_i |
| busy_o | output | 1 | An inversion is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| inv_o | output | 255 | Inverse of the last operand |
| mul_req_o | output | 1 | Product request to the external multiplier |
| mul_sq_o | output | 1 | The current request is a squaring |
| mul_a_o | output | 255 | First multiplier operand |
| mul_b_o | output | 255 | Second multiplier operand |
| mul_ack_i | input | 1 | Multiplier result valid; ends the current request |
| mul_res_i | input | 255 | Reduced product from the multiplier |

## Verification
The bench builds the block with WIDTH = 255, which is the only width the fixed schedule fits. Its multiplier model answers each request after a two-cycle wait, so every request rests on the port for several cycles. That exposes any operand that changes early and any start pulse injected in the middle of a segment. The short acknowledgement latency keeps a full 265-product run near a thousand cycles. This leaves room for operands of one, two, p − 1, zero and several arbitrary values, each with its product tally and its done-pulse width checked.

// File: rtl/inv_pkg.sv
package inv_pkg;
  localparam int unsigned SEG_N     = 12;
  localparam int unsigned SEG_W     = 4;
  localparam int unsigned NSQ_W     = 7;
  localparam int unsigned SLOT_N    = 4;
  localparam int unsigned SLOT_W    = 2;
  localparam int unsigned TOTAL_OPS = 265;
  localparam int unsigned SQ_OPS    = 254;

  typedef struct packed {
    logic [NSQ_W-1:0]  nsq;
    logic              mul_en;
    logic [SLOT_W-1:0] mul_slot;
    logic              save_en;
    logic [SLOT_W-1:0] save_slot;
  } seg_t;

  // Segment: square acc nsq times, optionally multiply by a slot, optionally save.
  function automatic seg_t seg_entry(logic [SEG_W-1:0] idx);
    seg_t s;
    case (idx)
      4'd0:    s = '{7'd1,   1'b0, 2'd0, 1'b1, 2'd1}; // a^2 -> s1
      4'd1:    s = '{7'd2,   1'b1, 2'd0, 1'b1, 2'd2}; // a^9 -> s2
      4'd2:    s = '{7'd0,   1'b1, 2'd1, 1'b1, 2'd0}; // a^11 -> s0
      4'd3:    s = '{7'd1,   1'b1, 2'd2, 1'b1, 2'd1}; // 2^5-1 -> s1
      4'd4:    s = '{7'd5,   1'b1, 2'd1, 1'b1, 2'd1}; // 2^10-1 -> s1
      4'd5:    s = '{7'd10,  1'b1, 2'd1, 1'b1, 2'd2}; // 2^20-1 -> s2
      4'd6:    s = '{7'd20,  1'b1, 2'd2, 1'b0, 2'd0}; // 2^40-1
      4'd7:    s = '{7'd10,  1'b1, 2'd1, 1'b1, 2'd2}; // 2^50-1 -> s2
      4'd8:    s = '{7'd50,  1'b1, 2'd2, 1'b1, 2'd3}; // 2^100-1 -> s3
      4'd9:    s = '{7'd100, 1'b1, 2'd3, 1'b0, 2'd0}; // 2^200-1
      4'd10:   s = '{7'd50,  1'b1, 2'd2, 1'b0, 2'd0}; // 2^250-1
      4'd11:   s = '{7'd5,   1'b1, 2'd0, 1'b0, 2'd0}; // p-2
      default: s = '0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/inv_chain_rom.sv
module inv_chain_rom
  import inv_pkg::*;
(
  input  logic [SEG_W-1:0] idx_i,
  output seg_t             seg_o
);
  always_comb seg_o = seg_entry(idx_i);
endmodule

// File: rtl/inv_slot_file.sv
module inv_slot_file #(
  parameter int unsigned WIDTH  = 255,
  parameter int unsigned SLOT_N = 4,
  parameter int unsigned SLOT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic [WIDTH-1:0]  init_val_i,
  input  logic              wr_en_i,
  input  logic [SLOT_W-1:0] wr_slot_i,
  input  logic [WIDTH-1:0]  wr_val_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  output logic [WIDTH-1:0]  rd_val_o
);
  logic [WIDTH-1:0] slot_q [SLOT_N];

  for (genvar g = 0; g < SLOT_N; g++) begin : g_slot
    // slot 0 receives the operand at start; the others clear
    localparam bit IS_BASE = (g == 0);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    slot_q[g] <= '0;
      else if (init_i)                                slot_q[g] <= IS_BASE ? init_val_i : '0;
      else if (wr_en_i && wr_slot_i == SLOT_W'(g))    slot_q[g] <= wr_val_i;
    end
  end

  assign rd_val_o = slot_q[rd_slot_i];
endmodule

// File: rtl/inv_chain_seq.sv
module inv_chain_seq
  import inv_pkg::*;
#(
  parameter int unsigned WIDTH = 255
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WIDTH-1:0] a_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] inv_o,
  output logic             mul_req_o,
  output logic             mul_sq_o,
  output logic [WIDTH-1:0] mul_a_o,
  output logic [WIDTH-1:0] mul_b_o,
  input  logic             mul_ack_i,
  input  logic [WIDTH-1:0] mul_res_i
);
  localparam logic [SEG_W-1:0] LAST_SEG = SEG_W'(SEG_N - 1);

  logic             busy_q, done_q, in_mul_q;
  logic [SEG_W-1:0] seg_q;
  logic [NSQ_W-1:0] sq_cnt_q;
  logic [WIDTH-1:0] acc_q, inv_q, slot_rd;
  seg_t             cur_seg, nxt_seg;
  logic             accept, step, last_sq, seg_end, save_now;

  inv_chain_rom u_rom_cur (.idx_i(seg_q),         .seg_o(cur_seg));
  inv_chain_rom u_rom_nxt (.idx_i(seg_q + 4'd1),  .seg_o(nxt_seg));

  assign accept   = start_i && !busy_q;
  assign step     = busy_q && mul_ack_i;
  assign last_sq  = !in_mul_q && (sq_cnt_q + 7'd1 == cur_seg.nsq);
  assign seg_end  = in_mul_q || (last_sq && !cur_seg.mul_en);
  assign save_now = step && seg_end && cur_seg.save_en;

  inv_slot_file #(.WIDTH(WIDTH), .SLOT_N(SLOT_N), .SLOT_W(SLOT_W)) u_slots (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_i     (accept),
    .init_val_i (a_i),
    .wr_en_i    (save_now),
    .wr_slot_i  (cur_seg.save_slot),
    .wr_val_i   (mul_res_i),
    .rd_slot_i  (cur_seg.mul_slot),
    .rd_val_o   (slot_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      in_mul_q <= 1'b0;
      seg_q    <= '0;
      sq_cnt_q <= '0;
      acc_q    <= '0;
      inv_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q   <= 1'b1;
        acc_q    <= a_i;
        seg_q    <= '0;
        sq_cnt_q <= '0;
        in_mul_q <= 1'b0;
      end else if (step) begin
        acc_q <= mul_res_i;
        if (seg_end) begin
          sq_cnt_q <= '0;
          seg_q    <= seg_q + 4'd1;
          in_mul_q <= (nxt_seg.nsq == '0);
          if (seg_q == LAST_SEG) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            inv_q  <= mul_res_i;
          end
        end else if (last_sq) begin
          in_mul_q <= 1'b1;
        end else begin
          sq_cnt_q <= sq_cnt_q + 7'd1;
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign inv_o     = inv_q;
  assign mul_req_o = busy_q;
  assign mul_sq_o  = !in_mul_q;
  assign mul_a_o   = acc_q;
  assign mul_b_o   = in_mul_q ? slot_rd : acc_q;

  // Tallies observed at the multiplier port, used only by the properties below
  logic [8:0] ack_tally_q, sq_tally_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_tally_q <= '0;
      sq_tally_q  <= '0;
    end else if (accept) begin
      ack_tally_q <= '0;
      sq_tally_q  <= '0;
    end else if (mul_req_o && mul_ack_i) begin
      ack_tally_q <= ack_tally_q + 9'd1;
      if (mul_sq_o) sq_tally_q <= sq_tally_q + 9'd1;
    end
  end

  a_r2_total_ops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ack_tally_q == 9'(TOTAL_OPS));
  a_r3_square_ops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> sq_tally_q == 9'(SQ_OPS));
  a_r4_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mul_req_o && !mul_ack_i |=> mul_req_o && $stable(mul_a_o) && $stable(mul_b_o));
  a_r5_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r5_done_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(mul_ack_i) && !busy_o);
  a_r7_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i && !mul_ack_i |=> $stable(mul_a_o) && busy_o);
  a_r9_square_operands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mul_req_o && mul_sq_o |-> mul_a_o == mul_b_o);
endmodule

// File: tb/inv_chain_seq_tb_top.sv
module inv_chain_seq_tb_top;
  localparam int W   = 255;
  localparam int LAT = 2;
  localparam logic [W-1:0] P = (W'(1) << 255) - W'(19);

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, ack = 1'b0;
  logic [W-1:0] a_in = '0, res = '0;
  logic busy, done, req, sq;
  logic [W-1:0] inv, ma, mb;

  int n_chk = 0, n_fail = 0;
  int ops = 0, sq_ops = 0, gen_ops = 0, bad_sq = 0, hold_err = 0, seen = 0;

  typedef struct { logic [W-1:0] a; logic [W-1:0] exp; } item_t;
  item_t exp_q[$];

  always #2 clk = ~clk;

  inv_chain_seq #(.WIDTH(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .a_i(a_in),
    .busy_o(busy), .done_o(done), .inv_o(inv),
    .mul_req_o(req), .mul_sq_o(sq), .mul_a_o(ma), .mul_b_o(mb),
    .mul_ack_i(ack), .mul_res_i(res)
  );

  function automatic logic [W-1:0] mmul(logic [W-1:0] x, logic [W-1:0] y);
    logic [2*W-1:0] pr;
    pr = {{W{1'b0}}, x} * {{W{1'b0}}, y};
    return W'(pr % {{W{1'b0}}, P});
  endfunction

  function automatic logic [W-1:0] mpow(logic [W-1:0] x, logic [W-1:0] e);
    logic [W-1:0] r = W'(1);
    for (int i = W - 1; i >= 0; i--) begin
      r = mmul(r, r);
      if (e[i]) r = mmul(r, x);
    end
    return r;
  endfunction

  task automatic check(bit ok, string req_tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  // multiplier model
  initial begin
    logic [W-1:0] ca, cb;
    logic csq;
    wait (rst_n);
    forever begin
      @(negedge clk);
      if (req) begin
        ca = ma; cb = mb; csq = sq;
        repeat (LAT) @(negedge clk);
        if (!req || ma != ca || mb != cb) hold_err++;
        ops++;
        if (csq) begin
          sq_ops++;
          if (ca != cb) bad_sq++;
        end else gen_ops++;
        res = mmul(ca, cb);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
      end
    end
  end

  // monitor / scoreboard
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (done) begin
        it = exp_q.pop_front();
        check(inv == it.exp, "R1 inverse", inv, it.exp);
        if (it.a == '0) check(inv == '0, "R6 zero in zero out", inv, '0);
        else check(mmul(it.a, inv) == W'(1), "R1 a*inv==1", mmul(it.a, inv), W'(1));
        check(ops == 265, "R2 product count", W'(ops), W'(265));
        check(sq_ops == 254, "R3 squaring count", W'(sq_ops), W'(254));
        check(gen_ops == 11, "R3 general count", W'(gen_ops), W'(11));
        check(hold_err == 0, "R4 request hold", W'(hold_err), '0);
        check(bad_sq == 0, "R9 square operands", W'(bad_sq), '0);
        check(!busy, "R5 idle at done", W'(busy), '0);
        @(negedge clk);
        check(!done, "R5 done one cycle", W'(done), '0);
        check(inv == it.exp, "R5 result held", inv, it.exp);
        seen++;
      end
    end
  end

  task automatic run_inv(logic [W-1:0] a, bit poke);
    item_t it;
    int target;
    it.a = a; it.exp = mpow(a, P - W'(2));
    exp_q.push_back(it);
    ops = 0; sq_ops = 0; gen_ops = 0; bad_sq = 0; hold_err = 0;
    target = seen + 1;
    @(negedge clk); start = 1'b1; a_in = a;
    @(negedge clk); start = 1'b0; a_in = '0;
    if (poke) begin
      repeat (37) @(negedge clk);
      start = 1'b1; a_in = W'(5);   // R7: must be ignored
      @(negedge clk); start = 1'b0;
      check(busy, "R7 busy kept", W'(busy), W'(1));
    end
    wait (seen == target);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !req, "R8 reset control", {busy, done, req}, '0);
    check(inv == '0, "R8 reset result", inv, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!req, "R8 idle after reset", W'(req), '0);
    run_inv(W'(1), 1'b0);
    run_inv(W'(2), 1'b0);
    run_inv(P - W'(1), 1'b0);
    run_inv('0, 1'b0);
    run_inv(W'(255'h1234_5678_9abc_def0_0fed_cba9_8765_4321), 1'b1);
    run_inv(P - W'(255'h3_0000_0000_0000_00c7), 1'b0);
    run_inv({3'b010, {21{12'ha5c}}}, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule